// File: doc/BRIEF.md
# Stereo Serial Audio Receive Channel

This block receives a two-channel serial audio stream of the common inter-IC sound kind. It samples the serial data and word-select lines on single-cycle bit strobes in the system clock domain, rebuilds each left and right word, and stores each complete pair as one entry of a 16-deep FIFO. Software or a bus agent takes samples out with a two-step read, the left word first and then the right word. The right-word read consumes the entry.

A data-available status rises once the fill level reaches a programmed threshold. An overrun status is set when a finished pair finds the FIFO full. In that case the new pair is dropped and the stored pairs are kept. A read-clear pulse clears the overrun status. Each status has its own mask toward a single interrupt line.

The channel receives only when the global, receiver-block and channel enables are all high, and it always starts on a left slot boundary. Dropping the global or block enable empties the FIFO and resets the deserialiser. A flush request empties the FIFO only while the channel enable is low.

Top module: `i2sRxChannel`

## Requirements
- R1: Bits are taken on cycles where `bitStrobe` is high. `ws` = 0 marks the left slot and `ws` = 1 marks the right slot. `ws` changes value on the last bit of a slot, one bit ahead of the next slot's first bit. Words arrive MSB first, and the finished word sits in `rdData` with its last captured bit in bit 0.
- R2: `lenCode` sets how many leading bits of each slot are kept: 1 keeps 12, 2 keeps 16, 3 keeps 20, 4 keeps 24, 5 keeps 32. Codes 0, 6 and 7 keep every bit of the slot up to 32. A slot shorter than the length keeps all of its bits.
- R3: Pairs are stored only while `globalEn`, `blockEn` and `chanEn` are all 1. After `chanEn` rises, the first pair stored is the one whose left slot starts after the next right-slot end.
- R4: While `globalEn` or `blockEn` is 0, the FIFO is empty and slot tracking is reset. After re-enabling, reception restarts at a left slot boundary.
- R5: The FIFO holds 16 pairs and returns them in arrival order. It is empty after reset, and `rdData` is 0 after reset.
- R6: A pair that finishes while the FIFO holds 16 entries, with no consuming read in the same cycle, is dropped. The stored pairs stay unchanged and `overrunStatus` becomes 1.
- R7: A pulse on `ovrClr` clears `overrunStatus` on the next cycle. A drop in the same cycle wins over the clear.
- R8: A pulse on `rdLeft` loads the head entry's left word into `rdData`, and a pulse on `rdRight` loads its right word. Both appear one cycle after the pulse. A right read consumes the entry only if a left read came before it. Either read of an empty FIFO returns 0.
- R9: `availStatus` is 1 exactly when the fill level is at least `trigCode` + 1, so the threshold runs from 1 to 16.
- R10: A `flushReq` pulse empties the FIFO when `chanEn` is 0. It has no effect when `chanEn` is 1.
- R11: `irq` = (`availStatus` and not `maskAvail`) or (`overrunStatus` and not `maskOvr`). A mask value of 1 disables that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| globalEn | input | 1 | Global enable; low flushes and resets |
| blockEn | input | 1 | Receiver-block enable; low flushes and resets |
| chanEn | input | 1 | Channel enable |
| lenCode | input | 3 | Word length code |
| trigCode | input | 4 | Data-available threshold minus one |
| maskAvail | input | 1 | 1 masks the data-available interrupt |
| maskOvr | input | 1 | 1 masks the overrun interrupt |
| flushReq | input | 1 | FIFO flush pulse, honoured while chanEn is low |
| bitStrobe | input | 1 | One-cycle pulse marking a serial bit sample |
| ws | input | 1 | Word select, 0 left, 1 right |
| sdi | input | 1 | Serial data |
| rdLeft | input | 1 | Left-word read pulse |
| rdRight | input | 1 | Right-word read pulse |
| ovrClr | input | 1 | Overrun clear-on-read pulse |
| rdData | output | 32 | Read data, LSB aligned |
| availStatus | output | 1 | Fill level at or above threshold |
| overrunStatus | output | 1 | Overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume several things about the inputs. `bitStrobe` is a one-cycle pulse, and `ws` and `sdi` change only between strobes. `lenCode` and `trigCode` hold steady while the channel is enabled. `rdLeft` and `rdRight` are never high together. The bench meets these assumptions. It spaces strobes two cycles apart and drives them from a single task. It changes configuration only with `chanEn` low, and then sends a short right-to-left word-select preamble to re-arm the channel. It pauses strobes between bursts, so the serial stream stays continuous across pauses.

// File: rtl/i2sRxPkg.sv
package i2sRxPkg;

  localparam int SLOT_MAX = 32;
  localparam int SCNT_W   = $clog2(SLOT_MAX + 1);

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ZERO  = 2'd1,
    RD_LEFT  = 2'd2,
    RD_RIGHT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   sampleBit;
    logic   firstBit;
    logic   latchLeft;
    logic   pushPair;
    rdSel_e rdSel;
  } rxStrobes_t;

  // number of leading slot bits kept for a length code; out-of-range and 0 keep all
  function automatic logic [SCNT_W-1:0] wordLimit(input logic [2:0] code);
    case (code)
      3'd1:    wordLimit = SCNT_W'(12);
      3'd2:    wordLimit = SCNT_W'(16);
      3'd3:    wordLimit = SCNT_W'(20);
      3'd4:    wordLimit = SCNT_W'(24);
      default: wordLimit = SCNT_W'(SLOT_MAX);
    endcase
  endfunction

endpackage

// File: rtl/i2sRxDatapath.sv
module i2sRxDatapath
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdi,
  input  logic [2:0]          lenCode,
  input  rxStrobes_t          st,
  input  logic [PTR_W-1:0]    wrIdx,
  input  logic [PTR_W-1:0]    rdIdx,
  output logic [SLOT_MAX-1:0] rdData
);

  localparam int PAIR_W = 2 * SLOT_MAX;

  logic [SLOT_MAX-1:0] shiftQ, shiftD, leftHold;
  logic [SCNT_W-1:0]   cntQ, cntD, limit;
  logic [PAIR_W-1:0]   pairMem [DEPTH];

  assign limit = wordLimit(lenCode);

  // next deserialiser value: restart on a slot's first bit, stop shifting at the limit
  always_comb begin
    shiftD = shiftQ;
    cntD   = cntQ;
    if (st.sampleBit) begin
      if (st.firstBit) begin
        shiftD = {{(SLOT_MAX-1){1'b0}}, sdi};
        cntD   = SCNT_W'(1);
      end else if (cntQ < limit) begin
        shiftD = {shiftQ[SLOT_MAX-2:0], sdi};
        cntD   = cntQ + SCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      cntQ     <= '0;
      leftHold <= '0;
    end else begin
      shiftQ <= shiftD;
      cntQ   <= cntD;
      if (st.latchLeft) leftHold <= shiftD;
    end
  end

  always_ff @(posedge clk) begin
    if (st.pushPair) pairMem[wrIdx] <= {leftHold, shiftD};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      case (st.rdSel)
        RD_ZERO:  rdData <= '0;
        RD_LEFT:  rdData <= pairMem[rdIdx][PAIR_W-1:SLOT_MAX];
        RD_RIGHT: rdData <= pairMem[rdIdx][SLOT_MAX-1:0];
        default:  rdData <= rdData;
      endcase
    end
  end

  // bit counter never runs past the widest slot word
  assert_bitcount_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= SCNT_W'(SLOT_MAX));

  // a slot's first bit always restarts the count at one
  assert_first_bit_restarts_R1: assert property (@(posedge clk) disable iff (!rstN)
    (st.sampleBit && st.firstBit) |=> cntQ == SCNT_W'(1));

endmodule

// File: rtl/i2sRxControl.sv
module i2sRxControl
  import i2sRxPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int TRIG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalEn,
  input  logic              blockEn,
  input  logic              chanEn,
  input  logic [TRIG_W-1:0] trigCode,
  input  logic              maskAvail,
  input  logic              maskOvr,
  input  logic              flushReq,
  input  logic              bitStrobe,
  input  logic              ws,
  input  logic              rdLeft,
  input  logic              rdRight,
  input  logic              ovrClr,
  output rxStrobes_t        st,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx,
  output logic              availStatus,
  output logic              overrunStatus,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             wsPrev, afterEnd, armed, leftSeen, ovrQ;
  logic [PTR_W-1:0] wrQ, rdQ;
  logic [CNT_W-1:0] countQ;
  logic blockOn, rxActive, slotEnd, endLeft, endRight;
  logic full, empty, popNow, pushNow, dropNow, flushNow;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    bumpPtr = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    blockOn  = globalEn && blockEn;
    rxActive = blockOn && chanEn;
    slotEnd  = bitStrobe && blockOn && (ws != wsPrev);
    endLeft  = slotEnd && !wsPrev;
    endRight = slotEnd && wsPrev;
    full     = (countQ == CNT_W'(DEPTH));
    empty    = (countQ == '0);
    popNow   = blockOn && rdRight && !rdLeft && !empty && leftSeen;
    pushNow  = endRight && armed && (!full || popNow);
    dropNow  = endRight && armed && full && !popNow;
    flushNow = !blockOn || (flushReq && !chanEn);

    st.sampleBit = bitStrobe && blockOn;
    st.firstBit  = afterEnd;
    st.latchLeft = endLeft && armed;
    st.pushPair  = pushNow;
    if (rdLeft)       st.rdSel = empty ? RD_ZERO : RD_LEFT;
    else if (rdRight) st.rdSel = empty ? RD_ZERO : RD_RIGHT;
    else              st.rdSel = RD_NONE;
  end

  // slot tracking and arming at a right-slot end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev   <= 1'b0;
      afterEnd <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (!blockOn) begin
        wsPrev   <= 1'b0;
        afterEnd <= 1'b0;
      end else if (bitStrobe) begin
        wsPrev   <= ws;
        afterEnd <= slotEnd;
      end
      if (!rxActive)     armed <= 1'b0;
      else if (endRight) armed <= 1'b1;
    end
  end

  // FIFO pointers and read sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ      <= '0;
      rdQ      <= '0;
      countQ   <= '0;
      leftSeen <= 1'b0;
    end else if (flushNow) begin
      wrQ      <= '0;
      rdQ      <= '0;
      countQ   <= '0;
      leftSeen <= 1'b0;
    end else begin
      if (pushNow) wrQ <= bumpPtr(wrQ);
      if (popNow)  rdQ <= bumpPtr(rdQ);
      case ({pushNow, popNow})
        2'b10:   countQ <= countQ + CNT_W'(1);
        2'b01:   countQ <= countQ - CNT_W'(1);
        default: countQ <= countQ;
      endcase
      if (rdLeft)      leftSeen <= !empty;
      else if (popNow) leftSeen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovrQ <= 1'b0;
    else if (dropNow) ovrQ <= 1'b1;
    else if (ovrClr)  ovrQ <= 1'b0;
  end

  assign wrIdx         = wrQ;
  assign rdIdx         = rdQ;
  assign overrunStatus = ovrQ;
  assign availStatus   = (32'(countQ) >= 32'(trigCode) + 32'd1);
  assign irq           = (availStatus && !maskAvail) || (ovrQ && !maskOvr);

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));

  assert_no_write_into_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.pushPair |-> (!full || popNow));

  assert_drop_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (endRight && armed && full && !popNow && blockOn) |=> (overrunStatus && countQ == CNT_W'(DEPTH)));

  assert_clear_drops_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClr && !(endRight && armed && full)) |=> !overrunStatus);

  assert_disable_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn || !blockEn) |=> (countQ == '0 && !armed));

  assert_lone_right_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (blockOn && !flushReq && rdRight && !rdLeft && !leftSeen && !st.pushPair) |=> countQ == $past(countQ));

  assert_empty_not_avail_R9: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0) |-> !availStatus);

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (maskAvail && maskOvr) |-> !irq);

endmodule

// File: rtl/i2sRxChannel.sv
module i2sRxChannel
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        globalEn,
  input  logic        blockEn,
  input  logic        chanEn,
  input  logic [2:0]  lenCode,
  input  logic [3:0]  trigCode,
  input  logic        maskAvail,
  input  logic        maskOvr,
  input  logic        flushReq,
  input  logic        bitStrobe,
  input  logic        ws,
  input  logic        sdi,
  input  logic        rdLeft,
  input  logic        rdRight,
  input  logic        ovrClr,
  output logic [31:0] rdData,
  output logic        availStatus,
  output logic        overrunStatus,
  output logic        irq
);

  localparam int PTR_W = $clog2(DEPTH);

  rxStrobes_t       st;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  i2sRxControl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .TRIG_W(4)) ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .blockEn(blockEn), .chanEn(chanEn),
    .trigCode(trigCode), .maskAvail(maskAvail), .maskOvr(maskOvr), .flushReq(flushReq),
    .bitStrobe(bitStrobe), .ws(ws), .rdLeft(rdLeft), .rdRight(rdRight), .ovrClr(ovrClr),
    .st(st), .wrIdx(wrIdx), .rdIdx(rdIdx), .availStatus(availStatus),
    .overrunStatus(overrunStatus), .irq(irq)
  );

  i2sRxDatapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) data_i (
    .clk(clk), .rstN(rstN), .sdi(sdi), .lenCode(lenCode), .st(st),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: tb/i2sRxChannel_tb_top.sv
module i2sRxChannel_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEn = 0, blockEn = 0, chanEn = 0;
  logic [2:0] lenCode = 3'd5;
  logic [3:0] trigCode = 4'd0;
  logic maskAvail = 0, maskOvr = 0, flushReq = 0;
  logic bitStrobe = 0, ws = 0, sdi = 0;
  logic rdLeft = 0, rdRight = 0, ovrClr = 0;
  logic [31:0] rdData;
  logic availStatus, overrunStatus, irq;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] qL[$];
  logic [31:0] qR[$];
  bit mOvr = 0;

  always #4 clk = ~clk;

  i2sRxChannel dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .blockEn(blockEn), .chanEn(chanEn),
    .lenCode(lenCode), .trigCode(trigCode), .maskAvail(maskAvail), .maskOvr(maskOvr),
    .flushReq(flushReq), .bitStrobe(bitStrobe), .ws(ws), .sdi(sdi), .rdLeft(rdLeft),
    .rdRight(rdRight), .ovrClr(ovrClr), .rdData(rdData), .availStatus(availStatus),
    .overrunStatus(overrunStatus), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int keepBits(input logic [2:0] code);
    case (code)
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  // R2: first min(len, limit) bits of the slot, LSB aligned
  function automatic logic [31:0] expWord(input logic [63:0] v, input int len, input logic [2:0] code);
    int take;
    take = (len < keepBits(code)) ? len : keepBits(code);
    return 32'(v >> (len - take));
  endfunction

  function automatic logic [63:0] genSlot(input int len);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (len < 64) v = v & ((64'd1 << len) - 64'd1);
    return v;
  endfunction

  task automatic bitOut(input logic w, input logic d);
    @(negedge clk);
    bitStrobe = 1'b1; ws = w; sdi = d;
    @(negedge clk);
    bitStrobe = 1'b0;
  endtask

  // ws leads the slot by one bit: last bit of a slot carries the next channel
  task automatic sendSlot(input logic chan, input logic [63:0] v, input int len);
    for (int i = 0; i < len; i++) bitOut((i == len - 1) ? ~chan : chan, v[len-1-i]);
  endtask

  task automatic preamble();
    bitOut(1'b1, 1'b0);
    bitOut(1'b0, 1'b0);
  endtask

  task automatic modelPush(input logic [31:0] l, input logic [31:0] r);
    if (qL.size() == 16) mOvr = 1;
    else begin qL.push_back(l); qR.push_back(r); end
  endtask

  task automatic sendFrame(input int len, input bit store);
    logic [63:0] l, r;
    l = genSlot(len); r = genSlot(len);
    sendSlot(1'b0, l, len);
    sendSlot(1'b1, r, len);
    if (store) modelPush(expWord(l, len, lenCode), expWord(r, len, lenCode));
  endtask

  task automatic readPair(input string req);
    logic [31:0] eL, eR;
    eL = (qL.size() > 0) ? qL[0] : 32'd0;
    eR = (qR.size() > 0) ? qR[0] : 32'd0;
    @(negedge clk); rdLeft = 1'b1;
    @(negedge clk); rdLeft = 1'b0;
    check({req, " left word"}, rdData, eL);
    rdRight = 1'b1;
    @(negedge clk); rdRight = 1'b0;
    check({req, " right word"}, rdData, eR);
    if (qL.size() > 0) begin void'(qL.pop_front()); void'(qR.pop_front()); end
  endtask

  task automatic checkStatus(input string req);
    logic av, ir;
    av = (qL.size() >= int'(trigCode) + 1);
    ir = (av && !maskAvail) || (mOvr && !maskOvr);
    check({req, " avail"}, {31'd0, availStatus}, {31'd0, av});
    check({req, " overrun"}, {31'd0, overrunStatus}, {31'd0, mOvr});
    check({req, " irq"}, {31'd0, irq}, {31'd0, ir});
  endtask

  task automatic drainAll(input string req);
    while (qL.size() > 0) readPair(req);
  endtask

  task automatic rearm(input logic [2:0] code);
    @(negedge clk); chanEn = 1'b0;
    lenCode = code;
    @(negedge clk); chanEn = 1'b1;
    preamble();
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int seedDummy;
    int lens[4];
    seedDummy = $urandom(32'd715);
    lens = '{16, 24, 32, 40};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 reset rdData", rdData, 32'd0);
    checkStatus("R5 reset");

    // R1 basic path, 32-bit slots
    globalEn = 1; blockEn = 1; chanEn = 1;
    preamble();
    for (int i = 0; i < 3; i++) sendFrame(32, 1);
    checkStatus("R1 three pairs");
    drainAll("R1 order R5");
    checkStatus("R1 drained");

    // R2 every length code with assorted slot widths
    for (int c = 0; c < 8; c++) begin
      rearm(3'(c));
      for (int k = 0; k < 2; k++) sendFrame(lens[$urandom % 4], 1);
      drainAll("R2 length code");
    end

    // R3 channel disabled stores nothing
    rearm(3'd5);
    @(negedge clk); chanEn = 1'b0;
    preamble();
    sendFrame(32, 0);
    checkStatus("R3 channel off");
    // R3 enable mid-frame: that frame skipped, next one stored
    sendSlot(1'b0, genSlot(32), 32);
    @(negedge clk); chanEn = 1'b1;
    sendSlot(1'b1, genSlot(32), 32);
    checkStatus("R3 mid-frame enable");
    sendFrame(32, 1);
    checkStatus("R3 next left slot");
    drainAll("R3 data");

    // R9 threshold 4
    trigCode = 4'd3;
    for (int i = 0; i < 3; i++) sendFrame(24, 1);
    checkStatus("R9 below threshold");
    sendFrame(24, 1);
    checkStatus("R9 at threshold");
    drainAll("R9 data");

    // R9 threshold 16, then R6 overrun keeps stored data
    trigCode = 4'd15;
    for (int i = 0; i < 15; i++) sendFrame(16, 1);
    checkStatus("R9 fifteen");
    sendFrame(16, 1);
    checkStatus("R9 full sixteen");
    sendFrame(16, 1);
    checkStatus("R6 overrun");
    // R11 masks
    maskAvail = 1; @(negedge clk); checkStatus("R11 avail masked");
    maskOvr = 1;   @(negedge clk); checkStatus("R11 both masked");
    maskAvail = 0; @(negedge clk); checkStatus("R11 ovr masked");
    maskOvr = 0;
    // R7 clear on read
    pulse(ovrClr); mOvr = 0;
    checkStatus("R7 cleared");
    drainAll("R6 stored kept");
    readPair("R8 empty reads zero");
    trigCode = 4'd0;

    // R8 lone right read does not consume
    sendFrame(32, 1); sendFrame(32, 1);
    @(negedge clk); rdRight = 1'b1;
    @(negedge clk); rdRight = 1'b0;
    check("R8 lone right data", rdData, qR[0]);
    drainAll("R8 pair after lone right");
    checkStatus("R8 drained");

    // R10 flush ignored with channel on, honoured with it off
    sendFrame(32, 1);
    pulse(flushReq);
    checkStatus("R10 flush ignored");
    @(negedge clk); chanEn = 1'b0;
    pulse(flushReq);
    qL.delete(); qR.delete();
    checkStatus("R10 flush honoured");
    readPair("R10 empty after flush");
    @(negedge clk); chanEn = 1'b1;
    preamble();

    // R4 global and block disable flush and reset
    sendFrame(32, 1); sendFrame(32, 1);
    @(negedge clk); globalEn = 1'b0;
    @(negedge clk); qL.delete(); qR.delete();
    checkStatus("R4 global off");
    globalEn = 1'b1;
    preamble();
    sendFrame(32, 1);
    @(negedge clk); blockEn = 1'b0;
    @(negedge clk); qL.delete(); qR.delete();
    checkStatus("R4 block off");
    blockEn = 1'b1;
    preamble();
    sendFrame(20, 1);
    drainAll("R4 restart");

    // random mix
    for (int it = 0; it < 25; it++) begin
      int nf;
      rearm(3'($urandom % 8));
      trigCode = 4'($urandom % 6);
      nf = $urandom % 5;
      for (int f = 0; f < nf; f++) sendFrame(lens[$urandom % 4], 1);
      checkStatus("R9 random level");
      drainAll("R2 random data");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule